// File: doc/BRIEF.md
# Multi-Port GPIO Output Data Block with Set and Clear Aliases

This block holds the output data bytes for several general-purpose I/O ports and sits behind a simple byte-wide register bus. Each port has three bus views. The direct view reads and writes the output data register as it is. The pin/set view returns the synchronized pin levels on a read and sets output bits on a write. The clear view clears output bits on a write and reads as zero.

The clear view uses write-zero-to-clear. A 0 in a written bit clears that output bit, and a 1 leaves it as it was. Software can therefore clear a group of bits with one byte write, and it does not need to read the register first.

Ports can be 4 to 8 bits wide, and each port's width is set by a parameter. Bits above a port's width are reserved. They read as zero, writes to them are ignored, and the matching output pins are driven low. Every access reaches exactly one register. Read data is registered and appears in the cycle after the read access.

Top module: `gpio_alias_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, every output data register is 0 and `bus_rdata` is 0.
- R2: A write to the direct view at address 0x00+p replaces the implemented bits of port p's output data register. A read there returns the register.
- R3: A write to the pin/set view at address 0x10+p sets each output bit of port p that has a 1 in the write data. Bits written with 0 are left as they were.
- R4: A write to the clear view at address 0x20+p clears each output bit of port p that has a 0 in the write data. Bits written with 1 are left as they were.
- R5: A read of any clear view address returns 0x00.
- R6: A read of the pin/set view returns the port's pin levels after a two-flop synchronizer, not the output data register. A pin change reaches a read that is captured on the third rising edge after the change.
- R7: With default widths 8, 7, 6 and 4 for ports 0 to 3, bits at and above a port's width read as 0, ignore writes, and drive 0 on `out_data`.
- R8: A read at an address that maps to no register returns 0. A write there changes no register.
- R9: `bus_rdata` carries the value read in the cycle after a read access (`bus_en`=1, `bus_we`=0), and is 0 in every other cycle.
- R10: A set or clear write takes effect on the rising edge that accepts it. `out_data` shows the new value in the following cycle, and so does a read of the direct view issued next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | NPORTS*8 | Pin levels, 8 bits for each port |
| out_data | output | NPORTS*8 | Output data registers, 8 bits for each port |

## Verification
A wrong output data register shows up on `out_data` in the cycle after the write that caused it. It also shows up on a direct-view read one cycle after that read is issued, so every write in the vector walk is followed by a readback. A swapped set/clear polarity, a wrong reserved-bit mask or a mis-decoded port index each leave a byte that differs from the expected value at the next readback. The depth of the synchronizer is checked through back-to-back pin reads: two reads return the old level and the third returns the new one, so one stage too many or too few moves the change by a cycle.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_DATA = 2'd1,
        RGN_PIN  = 2'd2,
        RGN_CLR  = 2'd3
    } region_e;

    typedef struct packed {
        logic [7:0] data;
    } port_state_t;

    typedef struct packed {
        logic [7:0] rdata;
    } bus_state_t;

    // Mask of implemented bits for a port of the given width (1..8)
    function automatic logic [7:0] width_mask(input int unsigned w);
        logic [31:0] m;
        m = (32'd1 << w) - 32'd1;
        return m[7:0];
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_alias_pkg::*;
#(
    parameter int unsigned             NPORTS    = 4,
    parameter int unsigned             ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]       DATA_BASE = 8'h00,
    parameter logic [ADDR_W-1:0]       PIN_BASE  = 8'h10,
    parameter logic [ADDR_W-1:0]       CLR_BASE  = 8'h20,
    localparam int unsigned            IDX_W     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(NPORTS);

    logic [ADDR_W:0]   ext;
    logic              hit_data, hit_pin, hit_clr;
    logic [ADDR_W-1:0] off_data, off_pin, off_clr;

    always_comb begin
        ext      = {1'b0, addr};
        hit_data = (ext >= {1'b0, DATA_BASE}) && (ext < ({1'b0, DATA_BASE} + SPAN));
        hit_pin  = (ext >= {1'b0, PIN_BASE})  && (ext < ({1'b0, PIN_BASE}  + SPAN));
        hit_clr  = (ext >= {1'b0, CLR_BASE})  && (ext < ({1'b0, CLR_BASE}  + SPAN));
        off_data = addr - DATA_BASE;
        off_pin  = addr - PIN_BASE;
        off_clr  = addr - CLR_BASE;
        region   = RGN_NONE;
        idx      = '0;
        if (hit_data) begin
            region = RGN_DATA;
            idx    = off_data[IDX_W-1:0];
        end else if (hit_pin) begin
            region = RGN_PIN;
            idx    = off_pin[IDX_W-1:0];
        end else if (hit_clr) begin
            region = RGN_CLR;
            idx    = off_clr[IDX_W-1:0];
        end
    end

    // R8: the three windows never overlap, so an access reaches one register at most
    a_r8_single_window: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_data, hit_pin, hit_clr}));

endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

    // R6: the second stage always takes what the first stage held one cycle earlier
    a_r6_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |=> q == $past(st_q.s1));

endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg
    import gpio_alias_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_direct,
    input  logic       wr_set,
    input  logic       wr_clr,
    input  logic [7:0] wdata,
    output logic [7:0] q
);
    localparam logic [7:0] MASK = width_mask(WIDTH);

    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_direct)   st_d.data = wdata & MASK;
        else if (wr_set) st_d.data = st_q.data | (wdata & MASK);
        else if (wr_clr) st_d.data = st_q.data & wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.data;

    // R3: a set-view write never lowers a bit
    a_r3_set_only_raises: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((q & $past(q)) == $past(q)));

    // R4: a clear-view write never raises a bit
    a_r4_clr_only_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((q & ~$past(q)) == 8'h00));

    // R2: without a write the register holds its value
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_direct || wr_set || wr_clr) |=> $stable(q));

    // R7: reserved bits stay low whatever is written
    a_r7_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_direct || wr_set) |=> ((q & ~MASK) == 8'h00));

endmodule

// File: rtl/gpio_alias_top.sv
module gpio_alias_top
    import gpio_alias_pkg::*;
#(
    parameter int unsigned             NPORTS     = 4,
    parameter logic [4*NPORTS-1:0]     WIDTH_CODE = 16'h4678,
    parameter logic [7:0]              DATA_BASE  = 8'h00,
    parameter logic [7:0]              PIN_BASE   = 8'h10,
    parameter logic [7:0]              CLR_BASE   = 8'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [7:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [NPORTS*8-1:0] pin_in,
    output logic [NPORTS*8-1:0] out_data
);
    localparam int unsigned IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    region_e          region;
    logic [IDX_W-1:0] idx;
    logic             do_wr, do_rd;
    logic [7:0]       data_arr [NPORTS];
    logic [7:0]       pin_arr  [NPORTS];
    logic [7:0]       mask_arr [NPORTS];
    bus_state_t       bs_d, bs_q;

    assign do_wr = bus_en &&  bus_we;
    assign do_rd = bus_en && !bus_we;

    gpio_addr_decode #(
        .NPORTS    (NPORTS),
        .ADDR_W    (8),
        .DATA_BASE (DATA_BASE),
        .PIN_BASE  (PIN_BASE),
        .CLR_BASE  (CLR_BASE)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .region (region),
        .idx    (idx)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int unsigned PW = WIDTH_CODE[4*p +: 4];
        logic sel;
        logic [7:0] pin_sync;

        assign sel = (idx == IDX_W'(p));
        assign mask_arr[p] = width_mask(PW);

        gpio_port_reg #(.WIDTH(PW)) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_direct (do_wr && sel && (region == RGN_DATA)),
            .wr_set    (do_wr && sel && (region == RGN_PIN)),
            .wr_clr    (do_wr && sel && (region == RGN_CLR)),
            .wdata     (bus_wdata),
            .q         (data_arr[p])
        );

        gpio_sync2 #(.W(8)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_in[8*p +: 8]),
            .q     (pin_sync)
        );

        assign pin_arr[p] = pin_sync & mask_arr[p];
        assign out_data[8*p +: 8] = data_arr[p];
    end

    always_comb begin
        bs_d.rdata = 8'h00;
        if (do_rd) begin
            case (region)
                RGN_DATA: bs_d.rdata = data_arr[idx];
                RGN_PIN:  bs_d.rdata = pin_arr[idx];
                default:  bs_d.rdata = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign bus_rdata = bs_q.rdata;

    // R5: the clear view reads as zero
    a_r5_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && region == RGN_CLR) |=> (bus_rdata == 8'h00));

    // R8: unmapped reads return zero
    a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && region == RGN_NONE) |=> (bus_rdata == 8'h00));

    // R8: unmapped writes change nothing
    a_r8_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && region == RGN_NONE) |=> $stable(out_data));

    // R9: read data appears only after a read access
    a_r9_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !do_rd |=> (bus_rdata == 8'h00));

endmodule

// File: tb/gpio_alias_top_test.sv
module gpio_alias_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [31:0] pin_in = 32'h96C35AA5;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_alias_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .out_data  (out_data)
    );

    // Vector fields: {we, addr, wdata, expected read, requirement number}
    localparam int NV = 26;
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 8'h00, 8'h3C, 8'h00, 8'd2},
        {1'b0, 8'h00, 8'h00, 8'h3C, 8'd2},
        {1'b1, 8'h10, 8'hC1, 8'h00, 8'd3},
        {1'b0, 8'h00, 8'h00, 8'hFD, 8'd3},
        {1'b1, 8'h20, 8'h0F, 8'h00, 8'd4},
        {1'b0, 8'h00, 8'h00, 8'h0D, 8'd4},
        {1'b0, 8'h20, 8'h00, 8'h00, 8'd5},
        {1'b0, 8'h10, 8'h00, 8'hA5, 8'd6},
        {1'b1, 8'h01, 8'hFF, 8'h00, 8'd7},
        {1'b0, 8'h01, 8'h00, 8'h7F, 8'd7},
        {1'b0, 8'h11, 8'h00, 8'h5A, 8'd6},
        {1'b0, 8'h12, 8'h00, 8'h03, 8'd7},
        {1'b0, 8'h13, 8'h00, 8'h06, 8'd7},
        {1'b1, 8'h03, 8'hFF, 8'h00, 8'd7},
        {1'b0, 8'h03, 8'h00, 8'h0F, 8'd7},
        {1'b1, 8'h23, 8'hFE, 8'h00, 8'd4},
        {1'b0, 8'h03, 8'h00, 8'h0E, 8'd4},
        {1'b1, 8'h12, 8'h80, 8'h00, 8'd7},
        {1'b0, 8'h02, 8'h00, 8'h00, 8'd7},
        {1'b1, 8'h40, 8'hFF, 8'h00, 8'd8},
        {1'b1, 8'h04, 8'hFF, 8'h00, 8'd8},
        {1'b0, 8'h40, 8'h00, 8'h00, 8'd8},
        {1'b0, 8'h04, 8'h00, 8'h00, 8'd8},
        {1'b0, 8'h00, 8'h00, 8'h0D, 8'd8},
        {1'b1, 8'h21, 8'hFF, 8'h00, 8'd4},
        {1'b0, 8'h01, 8'h00, 8'h7F, 8'd4}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    // Read: issue at one falling edge, sample the registered result at the next
    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        check("R1 reset out_data", out_data, 32'h0);
        check("R1 reset rdata", {24'h0, bus_rdata}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle out_data", out_data, 32'h0);
        check("R1 first cycle rdata", {24'h0, bus_rdata}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][32]) begin
                bus_write(VEC[v][31:24], VEC[v][23:16]);
            end else begin
                bus_read(VEC[v][31:24], rd);
                check($sformatf("R%0d vector %0d", VEC[v][7:0], v), {24'h0, rd}, {24'h0, VEC[v][15:8]});
            end
        end

        // R7 / R8: all port bytes after the walk, reserved bits low
        check("R7 out_data after walk", out_data, 32'h0E007F0D);

        // R9: rdata returns to zero the cycle after the read cycle
        @(negedge clk);
        check("R9 idle rdata", {24'h0, bus_rdata}, 32'h0);

        // R10: set write visible on out_data in the following cycle
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h12; bus_wdata = 8'h21;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        check("R10 set visible next cycle", {24'h0, out_data[23:16]}, 32'h21);
        bus_read(8'h02, rd);
        check("R10 set readback", {24'h0, rd}, 32'h21);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h22; bus_wdata = 8'hFE;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        check("R10 clear visible next cycle", {24'h0, out_data[23:16]}, 32'h20);

        // R6: synchronizer latency on back-to-back pin reads
        @(negedge clk);
        pin_in[7:0] = 8'h3C;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 8'h10;
        @(negedge clk);
        check("R6 sync read 1 old", {24'h0, bus_rdata}, 32'hA5);
        @(negedge clk);
        check("R6 sync read 2 old", {24'h0, bus_rdata}, 32'hA5);
        @(negedge clk);
        check("R6 sync read 3 new", {24'h0, bus_rdata}, 32'h3C);
        bus_en = 1'b0;

        // R6: pin read is not the output register
        bus_read(8'h10, rd);
        check("R6 pin view differs from data", {24'h0, rd}, 32'h3C);

        // R1: reset in mid-run clears all registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", out_data, 32'h0);
        rst_n = 1'b1;
        bus_read(8'h01, rd);
        check("R1 readback after reset", {24'h0, rd}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule